// File: doc/BRIEF.md
# Prefill-Count Warmup Evictor

This block sits beside a slice-organised expert weight cache. Each expert's quantized weights are held as two slices: a high-order slice that alone gives a coarse approximation, and a low-order slice that, added to the high-order one, restores full precision. While inference runs its prefill phase, every expert access is reported to the block. An access always touches the high-order slice. It also touches the low-order slice when the access asks for full precision. The block keeps a saturating access count and a resident flag for each slice.

When the phase input drops from prefill to decode, the block trims the cache down to a smaller decode budget. It chooses victims by the counts gathered during prefill, not by recency. It first removes low-order slices, least-used first. High-order slices are taken only once no low-order slice is left, again least-used first. Each removal is a one-cycle command carrying the expert index and the slice kind. A done flag reports that occupancy has reached the budget.

The control is a five-state machine:
- IDLE: counting.
- CHECK: compare occupancy against the budget.
- SCAN: sequential minimum search, one expert per cycle.
- EVICT: issue one command.
- DONE: trimmed.

Its transitions are:
- start-trim (IDLE→CHECK) on the prefill-to-decode edge.
- over-budget (CHECK→SCAN).
- within-budget (CHECK→DONE).
- victim-found (SCAN→EVICT) when the scan completes.
- recheck (EVICT→CHECK) after every command.
- new-prefill (DONE→IDLE) when the phase input returns to prefill.

Top module: `warmup_evictor`

## Requirements
- R1: While `phase_prefill` is 1, an accepted access adds one to the high-order count of `acc_expert`, and also adds one to its low-order count when `acc_hiprec` is 1. No count changes in any cycle where `phase_prefill` is 0.
- R2: Each count saturates at 2^CNT_W-1. Further accesses leave it at that value.
- R3: All counts return to zero in the first cycle of each new prefill phase (a 0→1 change of `phase_prefill`). An access in that same cycle counts as one.
- R4: Trimming begins only on a 1→0 change of `phase_prefill`. No eviction is issued while the phase stays at prefill, whatever the budget.
- R5: Low-order slices are evicted before any high-order slice. A high-order slice is never evicted while any low-order slice is resident, including its own.
- R6: Within a tier, the resident slice with the smallest prefill count is evicted first. Ties go to the lower expert index.
- R7: Eviction stops as soon as the number of resident slices (high plus low) is at or below `decode_budget`. If occupancy is already within the budget at the transition, `trim_done` rises with no eviction.
- R8: Each eviction is a single-cycle `evict_valid` pulse with `evict_expert` and `evict_lo` (1 = low-order slice, 0 = high-order slice). The evicted slice is no longer resident afterwards.
- R9: `trim_done` stays high from the end of trimming until prefill resumes, and no eviction is issued while it is high.
- R10: An access presented from the transition cycle until `trim_done` rises changes neither counts nor residency. Outside that window, every access marks the high-order slice resident, and also the low-order slice when `acc_hiprec` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_prefill | input | 1 | 1 = prefill phase, 0 = decode phase |
| acc_valid | input | 1 | Expert access strobe |
| acc_expert | input | IDX_W | Index of the accessed expert |
| acc_hiprec | input | 1 | Access also uses the low-order slice |
| decode_budget | input | OCC_W | Maximum resident slices allowed in decode |
| evict_valid | output | 1 | One-cycle eviction command |
| evict_expert | output | IDX_W | Expert whose slice is evicted |
| evict_lo | output | 1 | 1 = low-order slice evicted, 0 = high-order |
| trim_done | output | 1 | Trimming finished |

## Verification
The bench targets these corner cases:
- **Counter saturation.** Two experts are both pushed past the counter maximum. A wrapping counter would pick the wrong victim; a correct one ties them and picks the lower index.
- **Count reset.** Counts left over from an earlier prefill are set up so that failing to clear them reverses the eviction order.
- **Tier order.** A low-order slice with a high count sits beside a high-order slice with a low count. A design that ignores tiers would evict the high-order slice first.
- **Tie-break.** Equal counts check the lower-index rule.
- **Budget edges.** A budget already met must give done with zero commands. A budget of zero must drain everything in order.
- **Phase handling.** The phase is held at prefill with a zero budget, and no trimming may start. Accesses are injected during trimming. A design that still counts or marks slices resident in that window shows it through a changed victim order and through extra slices in the following drain.

// File: rtl/wm_pkg.sv
package wm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN,
        ST_EVICT,
        ST_DONE
    } trim_state_t;

endpackage

// File: rtl/wm_slice_counters.sv
module wm_slice_counters #(
    parameter int NUM_EXPERTS = 8,
    parameter int CNT_W       = 4,
    parameter int IDX_W       = $clog2(NUM_EXPERTS),
    parameter int OCC_W       = $clog2(2 * NUM_EXPERTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cnt_en,
    input  logic             set_en,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_hiprec,
    input  logic             drop_en,
    input  logic [IDX_W-1:0] drop_idx,
    input  logic             drop_lo,
    output logic [CNT_W-1:0] cnt_hi [NUM_EXPERTS],
    output logic [CNT_W-1:0] cnt_lo [NUM_EXPERTS],
    output logic [NUM_EXPERTS-1:0] res_hi,
    output logic [NUM_EXPERTS-1:0] res_lo,
    output logic [OCC_W-1:0] occupancy
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar g = 0; g < NUM_EXPERTS; g++) begin : g_slot
        logic             sel_acc;
        logic             sel_drop;
        logic [CNT_W-1:0] hi_q;
        logic [CNT_W-1:0] lo_q;
        logic [CNT_W-1:0] hi_base;
        logic [CNT_W-1:0] lo_base;
        logic             rh_q;
        logic             rl_q;

        assign sel_acc  = (acc_idx == IDX_W'(g));
        assign sel_drop = drop_en && (drop_idx == IDX_W'(g));
        assign hi_base  = clear ? '0 : hi_q;
        assign lo_base  = clear ? '0 : lo_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else begin
                if (cnt_en && sel_acc && hi_base != CNT_MAX)
                    hi_q <= hi_base + 1'b1;
                else
                    hi_q <= hi_base;
                if (cnt_en && sel_acc && acc_hiprec && lo_base != CNT_MAX)
                    lo_q <= lo_base + 1'b1;
                else
                    lo_q <= lo_base;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rh_q <= 1'b0;
                rl_q <= 1'b0;
            end else if (sel_drop) begin
                if (drop_lo) rl_q <= 1'b0;
                else         rh_q <= 1'b0;
            end else if (set_en && sel_acc) begin
                rh_q <= 1'b1;
                if (acc_hiprec) rl_q <= 1'b1;
            end
        end

        assign cnt_hi[g] = hi_q;
        assign cnt_lo[g] = lo_q;
        assign res_hi[g] = rh_q;
        assign res_lo[g] = rl_q;

        AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_q == CNT_MAX && !clear) |=> hi_q == CNT_MAX); // R2
        AST_LO_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
            rl_q |-> rh_q); // R5
    end

    always_comb begin
        occupancy = '0;
        for (int i = 0; i < NUM_EXPERTS; i++) begin
            occupancy = occupancy + OCC_W'(res_hi[i]) + OCC_W'(res_lo[i]);
        end
    end

endmodule

// File: rtl/wm_min_scan.sv
module wm_min_scan #(
    parameter int NUM_EXPERTS = 8,
    parameter int CNT_W       = 4,
    parameter int IDX_W       = $clog2(NUM_EXPERTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             use_lo,
    input  logic [CNT_W-1:0] cnt_hi [NUM_EXPERTS],
    input  logic [CNT_W-1:0] cnt_lo [NUM_EXPERTS],
    input  logic [NUM_EXPERTS-1:0] res_hi,
    input  logic [NUM_EXPERTS-1:0] res_lo,
    output logic             scan_done,
    output logic             best_found,
    output logic [IDX_W-1:0] best_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_EXPERTS - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] best_cnt_q;
    logic             cand_res;
    logic [CNT_W-1:0] cand_cnt;
    logic             better;

    assign cand_res = use_lo ? res_lo[idx_q] : res_hi[idx_q];
    assign cand_cnt = use_lo ? cnt_lo[idx_q] : cnt_hi[idx_q];
    // strict less-than keeps the earlier (lower) index on ties
    assign better   = cand_res && (!best_found || cand_cnt < best_cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            idx_q      <= '0;
            best_cnt_q <= '0;
            best_idx   <= '0;
            best_found <= 1'b0;
            scan_done  <= 1'b0;
        end else if (start) begin
            busy_q     <= 1'b1;
            idx_q      <= '0;
            best_found <= 1'b0;
            scan_done  <= 1'b0;
        end else if (busy_q) begin
            if (better) begin
                best_cnt_q <= cand_cnt;
                best_idx   <= idx_q;
                best_found <= 1'b1;
            end
            if (idx_q == LAST_IDX) begin
                busy_q    <= 1'b0;
                scan_done <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else begin
            scan_done <= 1'b0;
        end
    end

    AST_SCAN_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done); // R8
    AST_SCAN_FINDS: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> best_found); // R6

endmodule

// File: rtl/warmup_evictor.sv
module warmup_evictor #(
    parameter int NUM_EXPERTS = 8,
    parameter int CNT_W       = 4,
    parameter int IDX_W       = $clog2(NUM_EXPERTS),
    parameter int OCC_W       = $clog2(2 * NUM_EXPERTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_prefill,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_expert,
    input  logic             acc_hiprec,
    input  logic [OCC_W-1:0] decode_budget,
    output logic             evict_valid,
    output logic [IDX_W-1:0] evict_expert,
    output logic             evict_lo,
    output logic             trim_done
);
    import wm_pkg::*;

    trim_state_t state_q, state_d;
    logic        prev_phase_q;
    logic        tier_lo_q;
    logic        phase_fall, phase_rise;
    logic        accepting;
    logic        scan_start;

    logic [CNT_W-1:0]       cnt_hi [NUM_EXPERTS];
    logic [CNT_W-1:0]       cnt_lo [NUM_EXPERTS];
    logic [NUM_EXPERTS-1:0] res_hi, res_lo;
    logic [OCC_W-1:0]       occupancy;
    logic                   scan_done, best_found;
    logic [IDX_W-1:0]       best_idx;

    assign phase_fall = prev_phase_q && !phase_prefill;
    assign phase_rise = phase_prefill && !prev_phase_q;
    assign accepting  = acc_valid &&
                        ((state_q == ST_IDLE && phase_prefill) || state_q == ST_DONE);
    assign scan_start = (state_q == ST_CHECK) && (occupancy > decode_budget);

    wm_slice_counters #(
        .NUM_EXPERTS(NUM_EXPERTS), .CNT_W(CNT_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
    ) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (phase_rise),
        .cnt_en     (accepting && phase_prefill),
        .set_en     (accepting),
        .acc_idx    (acc_expert),
        .acc_hiprec (acc_hiprec),
        .drop_en    (evict_valid),
        .drop_idx   (evict_expert),
        .drop_lo    (evict_lo),
        .cnt_hi     (cnt_hi),
        .cnt_lo     (cnt_lo),
        .res_hi     (res_hi),
        .res_lo     (res_lo),
        .occupancy  (occupancy)
    );

    wm_min_scan #(
        .NUM_EXPERTS(NUM_EXPERTS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (scan_start),
        .use_lo     (tier_lo_q),
        .cnt_hi     (cnt_hi),
        .cnt_lo     (cnt_lo),
        .res_hi     (res_hi),
        .res_lo     (res_lo),
        .scan_done  (scan_done),
        .best_found (best_found),
        .best_idx   (best_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (phase_fall) state_d = ST_CHECK;
            ST_CHECK: state_d = (occupancy <= decode_budget) ? ST_DONE : ST_SCAN;
            ST_SCAN:  if (scan_done) state_d = ST_EVICT;
            ST_EVICT: state_d = ST_CHECK;
            ST_DONE:  if (phase_prefill) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, phase history and tier selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            prev_phase_q <= 1'b0;
            tier_lo_q    <= 1'b0;
        end else begin
            state_q      <= state_d;
            prev_phase_q <= phase_prefill;
            if (state_q == ST_CHECK) tier_lo_q <= |res_lo;
        end
    end

    // outputs
    always_comb begin
        evict_valid  = (state_q == ST_EVICT);
        evict_expert = best_idx;
        evict_lo     = tier_lo_q;
        trim_done    = (state_q == ST_DONE);
    end

    AST_EVICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> !evict_valid); // R8
    AST_VICTIM_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (evict_lo ? res_lo[evict_expert] : res_hi[evict_expert])); // R8
    AST_LO_TIER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !evict_lo) |-> (res_lo == '0)); // R5
    AST_DONE_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trim_done) |-> (occupancy <= decode_budget)); // R7
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trim_done |-> !evict_valid); // R9
    AST_NO_TRIM_IN_PREFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_prefill && prev_phase_q && state_q == ST_IDLE) |=> !evict_valid); // R4

    for (genvar g = 0; g < NUM_EXPERTS; g++) begin : g_chk
        AST_DECODE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            !phase_prefill |=> ($stable(cnt_hi[g]) && $stable(cnt_lo[g]))); // R1
    end

endmodule

// File: tb/warmup_evictor_bench.sv
module warmup_evictor_bench;

    localparam int N       = 8;
    localparam int CW      = 4;
    localparam int IW      = $clog2(N);
    localparam int OW      = $clog2(2 * N + 1);
    localparam int CNT_MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase_prefill = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_expert = '0;
    logic          acc_hiprec = 1'b0;
    logic [OW-1:0] decode_budget = '0;
    logic          evict_valid;
    logic [IW-1:0] evict_expert;
    logic          evict_lo;
    logic          trim_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench-side model built from the requirements
    int m_hi [N];
    int m_lo [N];
    bit m_rh [N];
    bit m_rl [N];
    int exp_idx [64];
    int exp_lo  [64];
    int n_exp;
    int log_idx [64];
    int log_lo  [64];
    int n_log = 0;

    warmup_evictor #(.NUM_EXPERTS(N), .CNT_W(CW)) u_warmup_evictor (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_prefill (phase_prefill),
        .acc_valid     (acc_valid),
        .acc_expert    (acc_expert),
        .acc_hiprec    (acc_hiprec),
        .decode_budget (decode_budget),
        .evict_valid   (evict_valid),
        .evict_expert  (evict_expert),
        .evict_lo      (evict_lo),
        .trim_done     (trim_done)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (evict_valid && n_log < 64) begin
            log_idx[n_log] = int'(evict_expert);
            log_lo[n_log]  = int'(evict_lo);
            n_log++;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic begin_prefill();
        @(negedge clk);
        acc_valid     = 1'b0;
        phase_prefill = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_hi[i] = 0;
            m_lo[i] = 0;
        end
    endtask

    task automatic access(input int e, input bit hp, input int times);
        for (int t = 0; t < times; t++) begin
            @(negedge clk);
            acc_valid  = 1'b1;
            acc_expert = IW'(e);
            acc_hiprec = hp;
            m_rh[e] = 1'b1;
            if (hp) m_rl[e] = 1'b1;
            if (m_hi[e] < CNT_MAX) m_hi[e]++;
            if (hp && m_lo[e] < CNT_MAX) m_lo[e]++;
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic build_expect(input int budget);
        int occ;
        n_exp = 0;
        occ = 0;
        for (int i = 0; i < N; i++) occ += int'(m_rh[i]) + int'(m_rl[i]);
        while (occ > budget) begin
            bit any_lo;
            int best;
            any_lo = 1'b0;
            best = -1;
            for (int i = 0; i < N; i++) if (m_rl[i]) any_lo = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (any_lo ? m_rl[i] : m_rh[i]) begin
                    if (best < 0) best = i;
                    else if ((any_lo ? m_lo[i] : m_hi[i]) < (any_lo ? m_lo[best] : m_hi[best]))
                        best = i;
                end
            end
            exp_idx[n_exp] = best;
            exp_lo[n_exp]  = int'(any_lo);
            n_exp++;
            if (any_lo) m_rl[best] = 1'b0;
            else        m_rh[best] = 1'b0;
            occ--;
        end
    endtask

    // drop to decode with a budget, optionally injecting accesses that must be ignored
    task automatic run_trim(input int budget, input string tag,
                            input int noise_e, input int noise_n);
        int waited;
        build_expect(budget);
        @(negedge clk);
        n_log = 0;
        decode_budget = OW'(budget);
        phase_prefill = 1'b0;
        acc_valid = 1'b0;
        for (int t = 0; t < noise_n; t++) begin
            acc_valid  = 1'b1;
            acc_expert = IW'(noise_e);
            acc_hiprec = 1'b1;
            @(negedge clk);
        end
        acc_valid = 1'b0;
        waited = 0;
        while (!trim_done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(trim_done == 1'b1, "R9", "trim_done after trimming", int'(trim_done), 1);
        check(n_log == n_exp, tag, "eviction count", n_log, n_exp);
        for (int k = 0; k < n_exp && k < n_log; k++) begin
            check(log_idx[k] == exp_idx[k], tag, "victim expert", log_idx[k], exp_idx[k]);
            check(log_lo[k] == exp_lo[k], "R5", "victim slice kind", log_lo[k], exp_lo[k]);
        end
        repeat (3) @(negedge clk);
        check(trim_done == 1'b1 && !evict_valid, "R9", "done holds quietly",
              int'(trim_done), 1);
    endtask

    task automatic flush();
        begin_prefill();
        run_trim(0, "R7", 0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(evict_valid == 1'b0, "R8", "evict_valid at reset", int'(evict_valid), 0);
        check(trim_done == 1'b0, "R9", "trim_done at reset", int'(trim_done), 0);
    endtask

    task automatic t_stay_prefill();
        begin_prefill();
        access(1, 1'b1, 2);
        decode_budget = '0;
        n_log = 0;
        repeat (40) @(negedge clk);
        check(n_log == 0, "R4", "evictions while in prefill", n_log, 0);
        check(trim_done == 1'b0, "R4", "done while in prefill", int'(trim_done), 0);
        run_trim(0, "R4", 0, 0);
    endtask

    task automatic t_within_budget();
        flush();
        begin_prefill();
        access(0, 1'b0, 1);
        access(1, 1'b1, 1);
        run_trim(5, "R7", 0, 0);
        check(n_log == 0, "R7", "no eviction within budget", n_log, 0);
    endtask

    task automatic t_order_basic();
        flush();
        begin_prefill();
        access(0, 1'b0, 3);
        access(1, 1'b1, 1);
        access(2, 1'b0, 2);
        access(1, 1'b1, 1);
        access(3, 1'b1, 4);
        access(5, 1'b0, 1);
        run_trim(2, "R6", 0, 0);
    endtask

    task automatic t_ties();
        flush();
        begin_prefill();
        access(5, 1'b0, 1);
        access(2, 1'b0, 1);
        access(6, 1'b0, 1);
        run_trim(0, "R6", 0, 0);
    endtask

    task automatic t_saturation();
        flush();
        begin_prefill();
        access(3, 1'b0, 20);
        access(4, 1'b0, 16);
        run_trim(1, "R2", 0, 0);
    endtask

    task automatic t_lo_before_hi();
        flush();
        begin_prefill();
        access(0, 1'b0, 1);
        access(1, 1'b1, 10);
        run_trim(2, "R5", 0, 0);
    endtask

    task automatic t_clear_on_prefill();
        flush();
        begin_prefill();
        access(0, 1'b0, 5);
        run_trim(16, "R3", 0, 0);
        begin_prefill();
        access(1, 1'b0, 3);
        access(0, 1'b0, 1);
        run_trim(1, "R3", 0, 0);
    endtask

    task automatic t_ignore_during_trim();
        flush();
        begin_prefill();
        access(0, 1'b0, 1);
        access(1, 1'b0, 2);
        access(2, 1'b0, 3);
        run_trim(1, "R10", 0, 6);
        begin_prefill();
        run_trim(0, "R10", 0, 0);
    endtask

    task automatic t_drain_all();
        flush();
        begin_prefill();
        access(7, 1'b1, 2);
        access(4, 1'b1, 2);
        access(6, 1'b0, 1);
        run_trim(0, "R8", 0, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_hi[i] = 0; m_lo[i] = 0; m_rh[i] = 1'b0; m_rl[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stay_prefill();
        t_within_budget();
        t_order_basic();
        t_ties();
        t_saturation();
        t_lo_before_hi();
        t_clear_on_prefill();
        t_ignore_during_trim();
        t_drain_all();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule